// File: doc/BRIEF.md
# Multi-Mode Interrupt Source Arbiter

This block chooses which of 48 interrupt request lines is in service. The lines come in four groups: eight external frame-group inputs, eight external general-purpose inputs, sixteen internal system-error flags and sixteen internal clock-error flags. An 8-bit mode input selects one of four behaviours. The first is a bypass, in which no arbitration takes place. The second is a flat round-robin across all 48 lines. The third and fourth are three-level priority schemes, one without and one with pre-emption of the interrupt in service.

The block registers its grant and reports it as a source index together with a valid flag. Service lasts until the consumer pulses an acknowledge. Request lines are level-sensitive. A line that is still high after losing arbitration, or after being pre-empted, competes again later. In bypass mode the block also reduces the system-error and clock-error groups to one flag each.

Top module: `irq_arbiter`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises, svc_valid_o is 0.
- R2: The mode input is decoded as follows: 0x01 is flat, 0x02 is tiered without pre-emption, 0x12 is tiered with pre-emption. Every other value is bypass, and in bypass svc_valid_o is 0 from the next cycle on.
- R3: In bypass, sys_err_o is the OR of sys_err_i and clk_err_o is the OR of clk_err_i, both combinationally. In any other mode both outputs are 0. In bypass, fg_req_i and gp_req_i have no effect on any output.
- R4: Source index map: fg_req_i[k] is k, gp_req_i[k] is 8+k, sys_err_i[k] is 16+k and clk_err_i[k] is 32+k.
- R5: When no interrupt is in service and a request is pending in an arbitrating mode, the grant appears on svc_valid_o and svc_idx_o one clock edge later.
- R6: In flat mode all 48 lines have equal weight. The winner is the first pending index at or above a pointer, wrapping around. After each flat grant the pointer moves to the granted index plus one, modulo 48.
- R7: In the tiered modes the clock-error level beats the system-error level, and the system-error level beats the 16 external lines.
- R8: Inside a level the winner is chosen round-robin from that level's own pointer. After a grant from that level, the pointer moves to one past the granted position. Each of the three levels has its own pointer.
- R9: An interrupt in service stays in service with an unchanged index until ack_i is high at a clock edge. At that edge a new grant is made from the lines pending at that moment, with no idle cycle in between.
- R10: In mode 0x12, a pending request from a strictly higher level than the one in service replaces it at the next edge. An equal or lower level never pre-empts, and mode 0x02 never pre-empts.
- R11: A pre-empted line whose request is still high is granted again once the higher-level service is acknowledged and no higher level is pending.
- R12: If ack_i ends a service, or nothing is in service, and no line is pending, svc_valid_o is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 8 | Arbitration mode code |
| fg_req_i | input | 8 | External frame-group requests |
| gp_req_i | input | 8 | External general-purpose requests |
| sys_err_i | input | 16 | Internal system-error flags |
| clk_err_i | input | 16 | Internal clock-error flags |
| ack_i | input | 1 | End-of-service pulse |
| svc_valid_o | output | 1 | An interrupt is in service |
| svc_idx_o | output | 6 | Index of the interrupt in service |
| sys_err_o | output | 1 | Combined system error (bypass only) |
| clk_err_o | output | 1 | Combined clock error (bypass only) |

## Verification
Two events can land on the same edge: an acknowledge of the current service and the arrival of a higher-level request. In that case the block must treat the edge as a normal re-grant, not as a pre-emption. The tiered winner must come from the highest pending level, and only that level's pointer may move. The bench drives random acknowledges together with sparse random requests in every mode, so these coincidences occur often. Directed steps also place an acknowledge and a clock-error request on the same edge. A reference model advances its own pointers from the requirements and judges each cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    MODE_OFF      = 2'd0,
    MODE_FLAT     = 2'd1,
    MODE_TIER     = 2'd2,
    MODE_TIER_PRE = 2'd3
  } arb_mode_e;

  localparam logic [7:0] CODE_FLAT     = 8'h01;
  localparam logic [7:0] CODE_TIER     = 8'h02;
  localparam logic [7:0] CODE_TIER_PRE = 8'h12;

  function automatic arb_mode_e decode_mode(input logic [7:0] code);
    case (code)
      CODE_FLAT:     return MODE_FLAT;
      CODE_TIER:     return MODE_TIER;
      CODE_TIER_PRE: return MODE_TIER_PRE;
      default:       return MODE_OFF;
    endcase
  endfunction
endpackage

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
  parameter int N  = 16,
  parameter int OW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  output logic          vld_o,
  output logic [OW-1:0] idx_o
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q;

  // first pending at or after ptr_q, wrapping; lowest offset wins
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int j;
      j = int'(ptr_q) + k;
      if (j >= N) j = j - N;
      if (req_i[j]) begin
        vld_o = 1'b1;
        idx_o = OW'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (adv_i) ptr_q <= (idx_o == OW'(N - 1)) ? '0 : PW'(idx_o + OW'(1));
  end
endmodule

// File: rtl/irq_tier_sel.sv
module irq_tier_sel #(
  parameter int EXT_W = 16,
  parameter int SYS_W = 16,
  parameter int CLK_W = 16,
  parameter int OW    = 6
) (
  input  logic          ext_vld_i,
  input  logic [OW-1:0] ext_idx_i,
  input  logic          sys_vld_i,
  input  logic [OW-1:0] sys_idx_i,
  input  logic          clk_vld_i,
  input  logic [OW-1:0] clk_idx_i,
  output logic          vld_o,
  output logic [1:0]    lvl_o,
  output logic [OW-1:0] idx_o
);
  localparam int SYS_OFS = EXT_W;
  localparam int CLK_OFS = EXT_W + SYS_W;

  always_comb begin
    vld_o = ext_vld_i | sys_vld_i | clk_vld_i;
    if (clk_vld_i) begin
      lvl_o = 2'd2;
      idx_o = clk_idx_i + OW'(CLK_OFS);
    end else if (sys_vld_i) begin
      lvl_o = 2'd1;
      idx_o = sys_idx_i + OW'(SYS_OFS);
    end else begin
      lvl_o = 2'd0;
      idx_o = ext_idx_i;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int FG_W  = 8,
  parameter int GP_W  = 8,
  parameter int SYS_W = 16,
  parameter int CLK_W = 16,
  localparam int EXT_W = FG_W + GP_W,
  localparam int N_SRC = EXT_W + SYS_W + CLK_W,
  localparam int IW    = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       mode_i,
  input  logic [FG_W-1:0]  fg_req_i,
  input  logic [GP_W-1:0]  gp_req_i,
  input  logic [SYS_W-1:0] sys_err_i,
  input  logic [CLK_W-1:0] clk_err_i,
  input  logic             ack_i,
  output logic             svc_valid_o,
  output logic [IW-1:0]    svc_idx_o,
  output logic             sys_err_o,
  output logic             clk_err_o
);
  localparam int SYS_OFS = EXT_W;
  localparam int CLK_OFS = EXT_W + SYS_W;

  arb_mode_e mode;
  logic [EXT_W-1:0] ext_req;
  logic [N_SRC-1:0] all_req;
  logic flat_vld, ext_vld, sys_vld, clk_vld, tier_vld;
  logic [IW-1:0] flat_idx, ext_idx, sys_idx, clk_idx, tier_idx, gnt_idx;
  logic [1:0] tier_lvl, cur_lvl;
  logic take_new, preempt, grant, any_pend, tiered;
  logic flat_adv, ext_adv, sys_adv, clk_adv;
  logic valid_q;
  logic [IW-1:0] idx_q;

  assign mode    = decode_mode(mode_i);
  assign tiered  = (mode == MODE_TIER) || (mode == MODE_TIER_PRE);
  assign ext_req = {gp_req_i, fg_req_i};
  assign all_req = {clk_err_i, sys_err_i, ext_req};

  irq_rr_pick #(.N(N_SRC), .OW(IW)) u_flat (
    .clk_i, .rst_ni, .req_i(all_req), .adv_i(flat_adv), .vld_o(flat_vld), .idx_o(flat_idx));
  irq_rr_pick #(.N(EXT_W), .OW(IW)) u_ext (
    .clk_i, .rst_ni, .req_i(ext_req), .adv_i(ext_adv), .vld_o(ext_vld), .idx_o(ext_idx));
  irq_rr_pick #(.N(SYS_W), .OW(IW)) u_sys (
    .clk_i, .rst_ni, .req_i(sys_err_i), .adv_i(sys_adv), .vld_o(sys_vld), .idx_o(sys_idx));
  irq_rr_pick #(.N(CLK_W), .OW(IW)) u_clk (
    .clk_i, .rst_ni, .req_i(clk_err_i), .adv_i(clk_adv), .vld_o(clk_vld), .idx_o(clk_idx));

  irq_tier_sel #(.EXT_W(EXT_W), .SYS_W(SYS_W), .CLK_W(CLK_W), .OW(IW)) u_tier (
    .ext_vld_i(ext_vld), .ext_idx_i(ext_idx),
    .sys_vld_i(sys_vld), .sys_idx_i(sys_idx),
    .clk_vld_i(clk_vld), .clk_idx_i(clk_idx),
    .vld_o(tier_vld), .lvl_o(tier_lvl), .idx_o(tier_idx));

  always_comb begin
    if (idx_q >= IW'(CLK_OFS))      cur_lvl = 2'd2;
    else if (idx_q >= IW'(SYS_OFS)) cur_lvl = 2'd1;
    else                            cur_lvl = 2'd0;
  end

  assign any_pend = (mode == MODE_FLAT) ? flat_vld : tier_vld;
  assign take_new = (mode != MODE_OFF) && (!valid_q || ack_i);
  assign preempt  = (mode == MODE_TIER_PRE) && valid_q && !ack_i && tier_vld &&
                    (tier_lvl > cur_lvl);
  assign grant    = (take_new && any_pend) || preempt;
  assign gnt_idx  = (mode == MODE_FLAT) ? flat_idx : tier_idx;

  assign flat_adv = grant && (mode == MODE_FLAT);
  assign ext_adv  = grant && tiered && (tier_lvl == 2'd0);
  assign sys_adv  = grant && tiered && (tier_lvl == 2'd1);
  assign clk_adv  = grant && tiered && (tier_lvl == 2'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else if (mode == MODE_OFF) begin
      valid_q <= 1'b0;
    end else if (grant) begin
      valid_q <= 1'b1;
      idx_q   <= gnt_idx;
    end else if (take_new) begin
      valid_q <= 1'b0;
    end
  end

  assign svc_valid_o = valid_q;
  assign svc_idx_o   = idx_q;
  assign sys_err_o   = (mode == MODE_OFF) && (|sys_err_i);
  assign clk_err_o   = (mode == MODE_OFF) && (|clk_err_i);
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int FG_W  = 8,
  parameter int GP_W  = 8,
  parameter int SYS_W = 16,
  parameter int CLK_W = 16,
  parameter int IW    = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       mode_i,
  input logic [FG_W-1:0]  fg_req_i,
  input logic [GP_W-1:0]  gp_req_i,
  input logic [SYS_W-1:0] sys_err_i,
  input logic [CLK_W-1:0] clk_err_i,
  input logic             ack_i,
  input logic             svc_valid_o,
  input logic [IW-1:0]    svc_idx_o,
  input logic             sys_err_o,
  input logic             clk_err_o
);
  localparam int CLK_OFS = FG_W + GP_W + SYS_W;

  logic listed, no_pre, tier_any, none_pend;
  assign listed    = (mode_i == 8'h01) || (mode_i == 8'h02) || (mode_i == 8'h12);
  assign no_pre    = (mode_i == 8'h01) || (mode_i == 8'h02);
  assign tier_any  = (mode_i == 8'h02) || (mode_i == 8'h12);
  assign none_pend = !(|fg_req_i) && !(|gp_req_i) && !(|sys_err_i) && !(|clk_err_i);

  a_r2_unlisted_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !listed |=> !svc_valid_o);

  a_r3_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    listed |-> (!sys_err_o && !clk_err_o));

  a_r7_clk_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tier_any && (!svc_valid_o || ack_i) && (|clk_err_i))
      |=> (svc_valid_o && (svc_idx_o >= IW'(CLK_OFS))));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_pre && svc_valid_o && !ack_i) |=> (svc_valid_o && $stable(svc_idx_o)));

  a_r10_preempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == 8'h12) && svc_valid_o && !ack_i && (|clk_err_i) &&
     (svc_idx_o < IW'(CLK_OFS)))
      |=> (svc_valid_o && (svc_idx_o >= IW'(CLK_OFS))));

  a_r12_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (listed && (!svc_valid_o || ack_i) && none_pend) |=> !svc_valid_o);
endmodule

bind irq_arbiter irq_arbiter_chk #(
  .FG_W(FG_W), .GP_W(GP_W), .SYS_W(SYS_W), .CLK_W(CLK_W), .IW(IW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .fg_req_i(fg_req_i),
  .gp_req_i(gp_req_i), .sys_err_i(sys_err_i), .clk_err_i(clk_err_i),
  .ack_i(ack_i), .svc_valid_o(svc_valid_o), .svc_idx_o(svc_idx_o),
  .sys_err_o(sys_err_o), .clk_err_o(clk_err_o)
);

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] mode = 8'h00;
  logic [7:0] fg = '0, gp = '0;
  logic [15:0] sys = '0, cke = '0;
  logic ack = 1'b0;
  logic svc_v, sys_o, clk_o;
  logic [5:0] svc_i;

  int errors = 0;
  int checks = 0;

  // reference model state
  bit m_v = 0;
  int m_idx = 0;
  int m_pf = 0;
  int m_pl[3] = '{0, 0, 0};

  always #10 clk = ~clk;

  irq_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .fg_req_i(fg), .gp_req_i(gp),
    .sys_err_i(sys), .clk_err_i(cke), .ack_i(ack),
    .svc_valid_o(svc_v), .svc_idx_o(svc_i), .sys_err_o(sys_o), .clk_err_o(clk_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int dec(input logic [7:0] m);
    case (m)
      8'h01: return 1;
      8'h02: return 2;
      8'h12: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic int rr(input logic [47:0] v, input int base, input int n, input int p);
    for (int k = 0; k < n; k++) begin
      int j = (p + k) % n;
      if (v[base + j]) return j;
    end
    return -1;
  endfunction

  function automatic int tier_pick(input logic [47:0] v, input int minlvl);
    for (int l = 2; l > minlvl; l--) begin
      int j = rr(v, l * 16, 16, m_pl[l]);
      if (j >= 0) begin
        m_pl[l] = (j + 1) % 16;
        return l * 16 + j;
      end
    end
    return -1;
  endfunction

  function automatic void model_next(input logic [7:0] m, input logic [47:0] r, input bit a);
    int md = dec(m);
    int g = -1;
    bit tn;
    if (md == 0) begin
      m_v = 0;
      return;
    end
    tn = !m_v || a;
    if (tn) begin
      if (md == 1) begin
        g = rr(r, 0, 48, m_pf);
        if (g >= 0) m_pf = (g + 1) % 48;
      end else g = tier_pick(r, -1);
    end else if (md == 3) begin
      g = tier_pick(r, (m_idx >= 32) ? 2 : (m_idx >= 16) ? 1 : 0);
    end
    if (g >= 0) begin
      m_v = 1;
      m_idx = g;
    end else if (tn) m_v = 0;
  endfunction

  function automatic string tag(input logic [7:0] m);
    case (dec(m))
      1: return "R6";
      2: return "R7";
      3: return "R10";
      default: return "R2";
    endcase
  endfunction

  // drive at negedge, check comb outputs, advance one edge, check registered outputs
  task automatic step(input logic [7:0] m, input logic [47:0] r, input bit a);
    bit off;
    mode = m;
    {cke, sys, gp, fg} = r;
    ack = a;
    #1;
    off = (dec(m) == 0);
    chk(sys_o == (off && |r[31:16]), "R3 sys_err_o", sys_o, off && |r[31:16]);
    chk(clk_o == (off && |r[47:32]), "R3 clk_err_o", clk_o, off && |r[47:32]);
    model_next(m, r, a);
    @(posedge clk);
    @(negedge clk);
    chk(svc_v == m_v, {tag(m), " svc_valid_o"}, svc_v, m_v);
    if (m_v) chk(int'(svc_i) == m_idx, {tag(m), " svc_idx_o"}, svc_i, m_idx);
  endtask

  function automatic logic [47:0] b(input int i);
    return 48'd1 << i;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(svc_v == 1'b0, "R1 valid in reset", svc_v, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(svc_v == 1'b0, "R1 valid after reset", svc_v, 0);

    // pre-emption and return
    step(8'h12, b(3), 0);
    chk(svc_v && svc_i == 3, "R5 R4 fg3 granted", svc_i, 3);
    step(8'h12, b(3) | b(32), 0);
    chk(svc_v && svc_i == 32, "R10 clk pre-empts ext", svc_i, 32);
    step(8'h12, b(3), 1);
    chk(svc_v && svc_i == 3, "R11 R9 pre-empted returns", svc_i, 3);
    step(8'h12, b(20) | b(3), 0);
    chk(svc_i == 20, "R10 sys pre-empts ext", svc_i, 20);
    step(8'h12, b(21) | b(3), 0);
    chk(svc_i == 20, "R10 equal level no pre-empt", svc_i, 20);
    step(8'h12, 48'd0, 1);
    chk(svc_v == 0, "R12 idle after ack", svc_v, 0);

    // tiered without pre-emption
    step(8'h02, b(5) | b(20), 0);
    chk(svc_i == 20, "R7 sys over ext", svc_i, 20);
    step(8'h02, b(5) | b(20) | b(40), 0);
    chk(svc_i == 20, "R10 no pre-empt in 0x02", svc_i, 20);
    step(8'h02, b(5) | b(40), 1);
    chk(svc_i == 40, "R7 clk next", svc_i, 40);
    step(8'h02, b(5), 1);
    chk(svc_i == 5, "R7 ext last", svc_i, 5);
    step(8'h02, 48'd0, 1);
    // level pointer for sys sits at local 5 after grant of 20
    step(8'h02, b(18) | b(24), 0);
    chk(svc_i == 24, "R8 sys rr from pointer", svc_i, 24);
    step(8'h02, b(18) | b(24), 1);
    chk(svc_i == 18, "R8 sys rr wrap", svc_i, 18);
    step(8'h02, b(18) | b(24), 1);
    chk(svc_i == 24, "R8 sys rr again", svc_i, 24);

    // flat round-robin
    step(8'h01, b(2) | b(10) | b(47), 1);
    chk(svc_i == 2, "R6 flat first", svc_i, 2);
    step(8'h01, b(2) | b(10) | b(47), 1);
    chk(svc_i == 10, "R6 flat second", svc_i, 10);
    step(8'h01, b(2) | b(10) | b(47), 1);
    chk(svc_i == 47, "R6 flat third", svc_i, 47);
    step(8'h01, b(2) | b(10) | b(47), 1);
    chk(svc_i == 2, "R6 flat wrap", svc_i, 2);

    // bypass and unlisted codes
    step(8'h00, 48'h0000_0002_FFFF, 0);
    chk(svc_v == 0 && sys_o == 1 && clk_o == 0, "R3 bypass OR, ext ignored", sys_o, 1);
    step(8'h03, b(33), 0);
    chk(svc_v == 0 && clk_o == 1, "R2 unlisted is bypass", svc_v, 0);
    step(8'h11, b(1), 0);
    chk(svc_v == 0 && sys_o == 0 && clk_o == 0, "R3 ext only in bypass", svc_v, 0);

    // constrained random
    begin
      logic [7:0] codes[6] = '{8'h00, 8'h01, 8'h02, 8'h12, 8'h03, 8'h11};
      logic [7:0] cm = 8'h12;
      for (int n = 0; n < 4000; n++) begin
        logic [47:0] r;
        if (n % 60 == 0) cm = codes[$urandom_range(5)];
        r = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
        if ($urandom_range(7) == 0) r = '0;
        step(cm, r, $urandom_range(2) == 0);
      end
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule